// File: doc/BRIEF.md
# Packet Address Byte Compressor

This block sits in the transmit path of a serial packet link, between the request source and the packet encoder. For each request header it receives, it works out which bytes of the 32-bit address differ from the address of the last request sent. It then puts out a per-byte presence mask and only those address bytes. The receive side keeps its own copy of the previous address and fills in every byte whose mask bit is clear. Read responses carry no address, so they produce an empty mask, emit no bytes and leave the stored address alone.

A header is accepted with a ready/valid pair. The mask appears one cycle later. The present bytes follow one per cycle, most significant first, starting in that same cycle, and the final one is flagged. A disable control forces full four-byte addresses. A link restart input marks the stored address as unknown, so the next request again sends every byte. Line coding and serialisation are handled elsewhere.

Top module: `addr_compressor`

## Requirements
- R1: After synchronous reset, hdr_ready is 1 and mask_valid and byte_valid are 0. The first request after reset is sent with mask 4'b1111.
- R2: For a request with a valid stored address and the optimisation enabled, mask bit i (bit 0 = address bits 7:0, bit 3 = bits 31:24) is 1 exactly when address byte i differs from byte i of the previous request's address.
- R3: Present bytes come out one per cycle on byte_data, highest byte index first, skipping bytes whose mask bit is 0. The first byte comes out in the cycle after acceptance, and byte_last marks the final one.
- R4: A read response (hdr_kind 3) gives mask 4'b0000, emits no byte and leaves the stored previous address unchanged.
- R5: While opt_disable is 1 at acceptance, a request gets mask 4'b1111 and all four bytes are sent.
- R6: A cycle with link_restart at 1 invalidates the stored address, so the next request is sent with mask 4'b1111. hdr_ready is 0 during that cycle.
- R7: hdr_ready is 0 while address bytes are still pending. A header offered while hdr_ready is 0 is ignored.
- R8: mask_valid is 1 for exactly the one cycle after each accepted header, with mask_out holding that header's mask.
- R9: hdr_kind 0 (write), 1 (burst write) and 2 (read request) are all requests. Each compares against, and then replaces, the stored address.
- R10: A request whose address equals the stored valid address gives mask 4'b0000 and no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_restart | input | 1 | Invalidates the stored previous address |
| opt_disable | input | 1 | Forces all address bytes to be sent |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be accepted this cycle |
| hdr_kind | input | 2 | 0 write, 1 burst write, 2 read request, 3 read response |
| hdr_addr | input | 32 | Full header address |
| mask_valid | output | 1 | mask_out is valid |
| mask_out | output | 4 | Byte presence mask |
| byte_valid | output | 1 | byte_data is valid |
| byte_data | output | 8 | Address byte being sent |
| byte_last | output | 1 | Final address byte of the header |

## Verification
The bench sends a read response between two identical requests. A design that let responses overwrite the stored address would then send bytes where an empty mask is expected. It applies the disable control and a link restart while the stored address matches. A design that ignored either would send an empty mask instead of a full one. It offers headers while bytes are still going out and checks byte order and the last flag against a queue model. This catches a swapped emission order, a lost or repeated byte, and a header accepted while busy.

// File: rtl/addr_cmp_pkg.sv
package addr_cmp_pkg;
    localparam int ADDR_BITS = 32;
    localparam int LANE_BITS = 8;

    typedef enum logic [1:0] {
        KIND_WRITE = 2'd0,
        KIND_BURST = 2'd1,
        KIND_READ  = 2'd2,
        KIND_RESP  = 2'd3
    } pkt_kind_e;

    function automatic logic kind_is_request(input logic [1:0] kind);
        return kind != KIND_RESP;
    endfunction
endpackage

// File: rtl/acmp_prev_store.sv
module acmp_prev_store #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] prev_addr,
    output logic              prev_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr <= '0;
            prev_ok   <= 1'b0;
        end else if (clear) begin
            prev_ok   <= 1'b0;
        end else if (load) begin
            prev_addr <= load_addr;
            prev_ok   <= 1'b1;
        end
    end
endmodule

// File: rtl/acmp_byte_emit.sv
module acmp_byte_emit #(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W/BYTE_W-1:0] load_mask,
    input  logic [ADDR_W-1:0] load_addr,
    output logic              busy,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_last
);
    localparam int NB = ADDR_W / BYTE_W;

    logic [NB-1:0]     pend;
    logic [NB-1:0]     pend_nx;
    logic [ADDR_W-1:0] addr_q;
    int                sel;

    always_comb begin
        sel = 0;
        for (int i = 0; i < NB; i++) begin
            if (pend[i]) sel = i;
        end
        pend_nx      = pend;
        pend_nx[sel] = 1'b0;
    end

    assign busy       = |pend;
    assign byte_valid = |pend;
    assign byte_data  = addr_q[sel*BYTE_W +: BYTE_W];
    assign byte_last  = ($countones(pend) == 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            addr_q <= '0;
        end else if (load) begin
            pend   <= load_mask;
            addr_q <= load_addr;
        end else begin
            pend   <= pend_nx;
        end
    end

    // one byte leaves per cycle, so the pending count drops by exactly one
    assert_one_per_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !load) |=> ($countones(pend) == $countones($past(pend)) - 1));
    assert_load_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);
endmodule

// File: rtl/addr_compressor.sv
module addr_compressor
    import addr_cmp_pkg::*;
#(
    parameter int ADDR_W = ADDR_BITS,
    parameter int BYTE_W = LANE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_restart,
    input  logic              opt_disable,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [1:0]        hdr_kind,
    input  logic [ADDR_W-1:0] hdr_addr,
    output logic              mask_valid,
    output logic [ADDR_W/BYTE_W-1:0] mask_out,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_last
);
    localparam int NB = ADDR_W / BYTE_W;

    logic              busy;
    logic              accept;
    logic              is_req;
    logic [ADDR_W-1:0] prev_addr;
    logic              prev_ok;
    logic [NB-1:0]     diff;
    logic [NB-1:0]     mask_c;

    assign hdr_ready = !busy && !link_restart;
    assign accept    = hdr_valid && hdr_ready;
    assign is_req    = kind_is_request(hdr_kind);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign diff[g] = hdr_addr[g*BYTE_W +: BYTE_W] != prev_addr[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        if (!is_req)                      mask_c = '0;
        else if (opt_disable || !prev_ok) mask_c = '1;
        else                              mask_c = diff;
    end

    acmp_prev_store #(.ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clear     (link_restart),
        .load      (accept && is_req),
        .load_addr (hdr_addr),
        .prev_addr (prev_addr),
        .prev_ok   (prev_ok)
    );

    acmp_byte_emit #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_emit (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .load_mask  (mask_c),
        .load_addr  (hdr_addr),
        .busy       (busy),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_last  (byte_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_valid <= 1'b0;
            mask_out   <= '0;
        end else begin
            mask_valid <= accept;
            if (accept) mask_out <= mask_c;
        end
    end

    assert_mask_follows_accept_R8: assert property (@(posedge clk) disable iff (rst)
        accept |=> mask_valid);
    assert_resp_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && hdr_kind == KIND_RESP) |=> (mask_out == '0 && !byte_valid));
    assert_disable_full_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && opt_disable && hdr_kind != KIND_RESP) |=> (&mask_out && byte_valid));
    assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> !hdr_ready);
    assert_restart_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        link_restart |-> !hdr_ready);
    assert_bytes_contiguous_R3: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_last) |=> byte_valid);
endmodule

// File: tb/addr_compressor_test.sv
module addr_compressor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_restart = 1'b0;
    logic        opt_disable = 1'b0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [1:0]  hdr_kind = 2'd0;
    logic [31:0] hdr_addr = 32'd0;
    logic        mask_valid;
    logic [3:0]  mask_out;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_last;

    int errors = 0;
    int checks = 0;
    string tag = "R1";

    // reference model state
    logic [7:0]  q[$];
    logic [31:0] m_prev = 0;
    bit          m_ok = 0;
    bit          m_mv = 0;
    logic [3:0]  m_mask = 0;

    always #2 clk = ~clk;

    addr_compressor uut (
        .clk(clk), .rst(rst), .link_restart(link_restart), .opt_disable(opt_disable),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_kind(hdr_kind), .hdr_addr(hdr_addr),
        .mask_valid(mask_valid), .mask_out(mask_out), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_last(byte_last)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit v, input logic [1:0] k, input logic [31:0] a,
                       input bit dis, input bit rs);
        bit acc;
        bit rdy;
        logic [3:0] mk;
        @(negedge clk);
        hdr_valid = v; hdr_kind = k; hdr_addr = a; opt_disable = dis; link_restart = rs;
        #1;
        rdy = (q.size() == 0) && !rs;
        chk("R7 ready", {31'd0, hdr_ready}, {31'd0, rdy});
        chk("R8 mask_valid", {31'd0, mask_valid}, {31'd0, m_mv});
        if (m_mv) chk({tag, " mask"}, {28'd0, mask_out}, {28'd0, m_mask});
        chk("R3 byte_valid", {31'd0, byte_valid}, {31'd0, q.size() != 0});
        if (q.size() != 0) begin
            chk("R3 byte_data", {24'd0, byte_data}, {24'd0, q[0]});
            chk("R3 byte_last", {31'd0, byte_last}, {31'd0, q.size() == 1});
            void'(q.pop_front());
        end
        acc = v && rdy;
        m_mv = acc;
        if (rs) m_ok = 0;
        if (acc) begin
            if (k == 2'd3) mk = 4'b0000;
            else if (dis || !m_ok) mk = 4'b1111;
            else for (int i = 0; i < 4; i++) mk[i] = a[i*8 +: 8] != m_prev[i*8 +: 8];
            m_mask = mk;
            for (int i = 3; i >= 0; i--) if (mk[i]) q.push_back(a[i*8 +: 8]);
            if (k != 2'd3) begin m_prev = a; m_ok = 1; end
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [31:0] a, input bit dis);
        cyc(1'b1, k, a, dis, 1'b0);
        while (hdr_ready !== 1'b1 || q.size() != 0) cyc(1'b0, 2'd0, 32'd0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset ready", {31'd0, hdr_ready}, 32'd1);
        chk("R1 reset mask_valid", {31'd0, mask_valid}, 32'd0);
        chk("R1 reset byte_valid", {31'd0, byte_valid}, 32'd0);
        tag = "R1"; send(2'd0, 32'h1234_5678, 0);
        tag = "R2"; send(2'd0, 32'h1234_5699, 0);
        tag = "R9"; send(2'd2, 32'hAB34_56FF, 0);
        tag = "R4"; send(2'd3, 32'h0000_0000, 0);
        tag = "R10"; send(2'd1, 32'hAB34_56FF, 0);
        tag = "R5"; send(2'd0, 32'hAB34_56FF, 1);
        // R7: offer headers back to back while bytes are pending
        tag = "R7";
        cyc(1'b1, 2'd0, 32'h0102_0304, 0, 0);
        cyc(1'b1, 2'd0, 32'hFFFF_FFFF, 0, 0);
        cyc(1'b1, 2'd1, 32'hEEEE_EEEE, 0, 0);
        send(2'd0, 32'h0102_0304, 0);
        tag = "R6";
        cyc(1'b1, 2'd0, 32'h0102_0304, 0, 1);
        send(2'd0, 32'h0102_0304, 0);
        tag = "R2";
        r = 32'hC0DE_0001;
        for (int n = 0; n < 40; n++) begin
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            cyc(1'b1, r[1:0] == 2'd3 ? 2'd3 : r[1:0], (n % 3 == 0) ? r : {m_prev[31:8], r[7:0]},
                r[9] & r[10] & r[11], 1'b0);
        end
        repeat (6) cyc(1'b0, 2'd0, 32'd0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule